// File: doc/BRIEF.md
# DRAM Bus Read/Write Turnaround Controller

This block decides, cycle by cycle, which direction a memory data bus shared by a read queue and a write queue may use, and when the next burst of each kind may start. One four-state machine covers both directions. It has a steady read state, a steady write state, and a transitional state for each turnaround. In a transitional state the bus lies idle for the required gap after the last burst has left it. The machine chooses its direction from the queue-empty flags and from two flags that show the write queue's fill level against a high and a low mark.

Each head request reports whether its bank is already prepared, that is, whether its row is open. When it is not, the block runs a preparation interval of precharge plus activate time before that request may issue. When the machine turns from writes to reads, that interval starts in the same cycle as the switch decision and runs alongside the write-to-read gap. The first read therefore waits only for whichever of the two ends later. When it turns from reads to writes, write preparation starts only once the write state is reached. The issue strobes are single-cycle pulses that the surrounding command logic consumes. All timing values are elaboration parameters counted in clock cycles.

Top module: `rw_turnaround_ctrl`

## Requirements
- R1: A synchronous active-high reset puts `bus_dir` in the read state (code 0) and clears every turnaround and preparation count, whatever the state was before. With both queues empty after reset, neither strobe is asserted.
- R2: `bus_dir` encodes read=0, read-to-write=1, write=2 and write-to-read=3. From one cycle to the next it either holds or steps 0→1→2→3→0.
- R3: In the read state, with the high-mark flag low, reads take priority. A read strobe is given whenever the read queue is non-empty, the bus is free and the read head is ready, even while writes are pending.
- R4: The read state moves to read-to-write when the high-mark flag is set, even with reads pending, or when the read queue is empty and the write queue is not. No read strobe is given in the cycle that decides this.
- R5: The write state keeps issuing writes while neither the low-mark flag nor the write-empty flag is set, even with reads pending. It moves to write-to-read when either flag is set and reads are pending, and it stays in the write state when no reads are pending.
- R6: At most one strobe is asserted per cycle. `issue_rd` is asserted only in state 0 with the read queue non-empty, and `issue_wr` only in state 2 with the write queue non-empty.
- R7: Any two strobes are at least T_BURST cycles apart. With heads ready and no switch, successive strobes are exactly T_BURST cycles apart.
- R8: The first write strobe after a read strobe comes no earlier than T_BURST+T_RTW cycles after that read strobe. When the switch is decided while that read is still on the bus and the write head is ready, it comes exactly then.
- R9: The first read strobe after a write strobe comes no earlier than T_BURST+T_WTR cycles after that write strobe. When the switch is decided while that write is still on the bus and the read head is ready, it comes exactly then.
- R10: If the read head is not ready (bank-ready low) in the cycle that decides a write-to-read switch, its preparation of T_RP+T_RCD cycles starts in that cycle. The first read strobe comes at the later of (last write strobe + T_BURST + T_WTR) and (decision cycle + T_RP + T_RCD + 1).
- R11: Write preparation does not run during the read-to-write turnaround. A write head that is not ready is strobed exactly T_RP+T_RCD cycles after the cycle in which the write state is entered.
- R12: In the read state with the bus free, a read head that is not ready and is first presented in cycle s is strobed in cycle s+T_RP+T_RCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_empty | input | 1 | Read queue holds no request |
| wr_empty | input | 1 | Write queue holds no request |
| wr_hi_mark | input | 1 | Write queue at or above its high mark |
| wr_lo_mark | input | 1 | Write queue at or below its low mark |
| rd_bank_ready | input | 1 | Read head's row is open (1 = no preparation needed) |
| wr_bank_ready | input | 1 | Write head's row is open (1 = no preparation needed) |
| issue_rd | output | 1 | One-cycle strobe: start the read head's burst |
| issue_wr | output | 1 | One-cycle strobe: start the write head's burst |
| bus_dir | output | 2 | Bus state: 0 read, 1 read-to-write, 2 write, 3 write-to-read |

## Verification
The hardest situation to reach from the ports is the overlapped write-to-read turnaround, where the preparation interval and the bus gap overlap and either one may decide the first read. The stimulus drains the write queue to its low mark in the cycle right after a write strobe while a read is waiting. It does this once with the read head ready, so the gap decides, and once with the head not ready, so the preparation interval decides. The bench also drives a read-to-write switch with an unprepared write head, to show that the serial case costs the full sum of the two intervals. A queue of expected strobe cycles, built from the requirement formulas, is compared against every strobe the block produces.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

    typedef enum logic [1:0] {
        DIR_RD    = 2'd0,
        DIR_RD2WR = 2'd1,
        DIR_WR    = 2'd2,
        DIR_WR2RD = 2'd3
    } bus_dir_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/rwt_burst_timer.sv
module rwt_burst_timer #(
    parameter int unsigned T_BURST = 4,
    parameter int unsigned W       = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic bus_free
);
    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (start)
            left <= W'(T_BURST - 1);
        else if (left != '0)
            left <= left - W'(1);
    end

    assign bus_free = (left == '0);
endmodule

// File: rtl/rwt_gap_timer.sv
module rwt_gap_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         bus_free,
    output logic         expired
);
    logic [W-1:0] cnt;

    // The gap only runs once the previous burst has left the bus.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (bus_free && cnt > W'(1))
            cnt <= cnt - W'(1);
    end

    assign expired = bus_free && (cnt <= W'(1));
endmodule

// File: rtl/rwt_prep_timer.sv
module rwt_prep_timer #(
    parameter int unsigned T_PREP = 10,
    parameter int unsigned W      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic abandon,
    input  logic consume,
    output logic done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (consume) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (abandon) begin
            // target direction changes: drop old work, maybe start new
            done <= (start_req && T_PREP <= 1);
            cnt  <= (start_req && T_PREP > 1) ? W'(T_PREP - 1) : '0;
        end else if (start_req && !done && cnt == '0) begin
            if (T_PREP <= 1)
                done <= 1'b1;
            else
                cnt <= W'(T_PREP - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
            if (cnt == W'(1))
                done <= 1'b1;
        end
    end
endmodule

// File: rtl/rw_turnaround_ctrl.sv
module rw_turnaround_ctrl
    import rwt_pkg::*;
#(
    parameter int unsigned T_BURST = 4,
    parameter int unsigned T_RTW   = 2,
    parameter int unsigned T_WTR   = 6,
    parameter int unsigned T_RP    = 5,
    parameter int unsigned T_RCD   = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_empty,
    input  logic       wr_empty,
    input  logic       wr_hi_mark,
    input  logic       wr_lo_mark,
    input  logic       rd_bank_ready,
    input  logic       wr_bank_ready,
    output logic       issue_rd,
    output logic       issue_wr,
    output logic [1:0] bus_dir
);
    localparam int unsigned T_PREP  = T_RP + T_RCD;
    localparam int unsigned GAP_MAX = max2(T_RTW, T_WTR);
    localparam int unsigned CW      = cnt_width(max2(max2(T_PREP, GAP_MAX), T_BURST));

    bus_dir_e st, st_nxt;

    logic go_wr, go_rd;
    logic tgt_rd, tgt_wr;
    logic prep_start, prep_abandon, prep_done;
    logic bus_free, gap_expired;
    logic rd_ok, wr_ok;
    logic [CW-1:0] gap_val;

    // direction decisions
    assign go_wr = (st == DIR_RD) && (wr_hi_mark || (rd_empty && !wr_empty));
    assign go_rd = (st == DIR_WR) && !rd_empty && (wr_lo_mark || wr_empty);

    // which head the preparation engine works for; none during read-to-write
    assign tgt_rd = ((st == DIR_RD) && !go_wr) || (st == DIR_WR2RD) || go_rd;
    assign tgt_wr = (st == DIR_WR) && !go_rd;

    assign prep_start   = (tgt_rd && !rd_empty && !rd_bank_ready)
                        || (tgt_wr && !wr_empty && !wr_bank_ready);
    assign prep_abandon = go_wr || go_rd;

    assign rd_ok = rd_bank_ready || prep_done;
    assign wr_ok = wr_bank_ready || prep_done;

    assign issue_rd = (st == DIR_RD) && !go_wr && !rd_empty && bus_free && rd_ok;
    assign issue_wr = (st == DIR_WR) && !go_rd && !wr_empty && bus_free && wr_ok;

    assign gap_val = go_wr ? CW'(T_RTW) : CW'(T_WTR);

    rwt_burst_timer #(.T_BURST(T_BURST), .W(CW)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .start    (issue_rd || issue_wr),
        .bus_free (bus_free)
    );

    rwt_gap_timer #(.W(CW)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (go_wr || go_rd),
        .load_val (gap_val),
        .bus_free (bus_free),
        .expired  (gap_expired)
    );

    rwt_prep_timer #(.T_PREP(T_PREP), .W(CW)) u_prep (
        .clk       (clk),
        .rst       (rst),
        .start_req (prep_start),
        .abandon   (prep_abandon),
        .consume   (issue_rd || issue_wr),
        .done      (prep_done)
    );

    always_comb begin
        st_nxt = st;
        case (st)
            DIR_RD:    if (go_wr) st_nxt = DIR_RD2WR;
            DIR_RD2WR: if (gap_expired) st_nxt = DIR_WR;
            DIR_WR:    if (go_rd) st_nxt = DIR_WR2RD;
            DIR_WR2RD: if (gap_expired && (rd_ok || rd_empty)) st_nxt = DIR_RD;
            default:   st_nxt = DIR_RD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= DIR_RD;
        else
            st <= st_nxt;
    end

    assign bus_dir = st;
endmodule

// File: rtl/rw_turnaround_chk.sv
module rw_turnaround_chk
    import rwt_pkg::*;
#(
    parameter int unsigned T_BURST = 4,
    parameter int unsigned T_RTW   = 2,
    parameter int unsigned T_WTR   = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       rd_empty,
    input logic       wr_empty,
    input logic       issue_rd,
    input logic       issue_wr,
    input logic [1:0] bus_dir
);
    localparam int unsigned SAT = T_BURST + max2(T_RTW, T_WTR);
    localparam int unsigned W   = cnt_width(SAT);

    logic [W-1:0] since;
    logic         last_rd, last_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            since   <= W'(SAT);
            last_rd <= 1'b0;
            last_wr <= 1'b0;
        end else if (issue_rd || issue_wr) begin
            since   <= W'(1);
            last_rd <= issue_rd;
            last_wr <= issue_wr;
        end else if (since < W'(SAT)) begin
            since <= since + W'(1);
        end
    end

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !(issue_rd && issue_wr));
    p_rd_legal_r6: assert property (@(posedge clk) disable iff (rst)
        issue_rd |-> (bus_dir == 2'd0 && !rd_empty));
    p_wr_legal_r6: assert property (@(posedge clk) disable iff (rst)
        issue_wr |-> (bus_dir == 2'd2 && !wr_empty));
    p_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        (issue_rd || issue_wr) |-> (since >= W'(T_BURST)));
    p_rtw_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (issue_wr && last_rd) |-> (since >= W'(T_BURST + T_RTW)));
    p_wtr_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (issue_rd && last_wr) |-> (since >= W'(T_BURST + T_WTR)));
    p_step_rd_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_dir == 2'd0) |=> (bus_dir == 2'd0 || bus_dir == 2'd1));
    p_step_rtw_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_dir == 2'd1) |=> (bus_dir == 2'd1 || bus_dir == 2'd2));
    p_step_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_dir == 2'd2) |=> (bus_dir == 2'd2 || bus_dir == 2'd3));
    p_step_wtr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_dir == 2'd3) |=> (bus_dir == 2'd3 || bus_dir == 2'd0));
endmodule

bind rw_turnaround_ctrl rw_turnaround_chk #(
    .T_BURST (T_BURST),
    .T_RTW   (T_RTW),
    .T_WTR   (T_WTR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_empty (rd_empty),
    .wr_empty (wr_empty),
    .issue_rd (issue_rd),
    .issue_wr (issue_wr),
    .bus_dir  (bus_dir)
);

// File: tb/rw_turnaround_ctrl_tb_top.sv
`timescale 1ns/1ps
module rw_turnaround_ctrl_tb_top;
    localparam int T_BURST = 4;
    localparam int T_RTW   = 2;
    localparam int T_WTR   = 6;
    localparam int T_RP    = 5;
    localparam int T_RCD   = 5;
    localparam int T_PREP  = T_RP + T_RCD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_empty = 1'b1, wr_empty = 1'b1;
    logic wr_hi_mark = 1'b0, wr_lo_mark = 1'b1;
    logic rd_bank_ready = 1'b1, wr_bank_ready = 1'b1;
    logic issue_rd, issue_wr;
    logic [1:0] bus_dir;

    always #2.5 clk = ~clk;

    rw_turnaround_ctrl #(
        .T_BURST(T_BURST), .T_RTW(T_RTW), .T_WTR(T_WTR), .T_RP(T_RP), .T_RCD(T_RCD)
    ) dut_i (
        .clk(clk), .rst(rst), .rd_empty(rd_empty), .wr_empty(wr_empty),
        .wr_hi_mark(wr_hi_mark), .wr_lo_mark(wr_lo_mark),
        .rd_bank_ready(rd_bank_ready), .wr_bank_ready(wr_bank_ready),
        .issue_rd(issue_rd), .issue_wr(issue_wr), .bus_dir(bus_dir)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    wr;
        string req;
    } exp_t;
    exp_t sb[$];

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_issue(input int at, input bit wr, input string req);
        exp_t e;
        e.at = at; e.wr = wr; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic check_dir(input int n, input logic [1:0] expv, input string req);
        wait_to(n);
        #1;
        check(bus_dir == expv, req, "bus_dir", int'(bus_dir), int'(expv));
    endtask

    task automatic drain_check(input string req);
        check(sb.size() == 0, req, "expected strobes never seen", sb.size(), 0);
        sb.delete();
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: compare each strobe against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && (issue_rd || issue_wr)) begin
                if (issue_rd && issue_wr) begin
                    check(1'b0, "R6", "both strobes in one cycle", 1, 0);
                end else if (sb.size() == 0) begin
                    check(1'b0, "R6", "strobe with none expected, cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.at == cyc, e.req, e.wr ? "write strobe cycle" : "read strobe cycle",
                          cyc, e.at);
                    check(issue_wr == e.wr, e.req, "strobe kind (1=write)",
                          int'(issue_wr), int'(e.wr));
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_up();
    end

    initial begin
        int c, d, e;
        repeat (4) @(negedge clk);
        #1;
        check(bus_dir == 2'd0, "R1", "bus_dir during reset", int'(bus_dir), 0);
        check(!issue_rd && !issue_wr, "R1", "strobes during reset",
              int'(issue_rd) + int'(issue_wr), 0);
        @(negedge clk);
        rst = 1'b0;
        check_dir(cyc + 2, 2'd0, "R1");

        // reads with priority, switch on empty read queue, write hysteresis
        c = cyc + 3;
        wait_to(c);
        rd_empty = 1'b0; wr_empty = 1'b0; wr_lo_mark = 1'b0; wr_hi_mark = 1'b0;
        expect_issue(c,      1'b0, "R3");
        expect_issue(c + 4,  1'b0, "R7");
        expect_issue(c + 8,  1'b0, "R7");
        expect_issue(c + 8 + T_BURST + T_RTW, 1'b1, "R8");
        expect_issue(c + 18, 1'b1, "R7");
        expect_issue(c + 22, 1'b1, "R5");
        expect_issue(c + 22 + T_BURST + T_WTR, 1'b0, "R9");
        wait_to(c + 9);
        rd_empty = 1'b1;
        check_dir(c + 10, 2'd1, "R4");
        wait_to(c + 15);
        rd_empty = 1'b0;
        check_dir(c + 16, 2'd2, "R2");
        wait_to(c + 23);
        wr_lo_mark = 1'b1;
        check_dir(c + 24, 2'd3, "R5");
        wait_to(c + 33);
        rd_empty = 1'b1; wr_empty = 1'b1;
        check_dir(c + 40, 2'd0, "R2");
        drain_check("R9");

        // high mark with reads pending, then overlapped preparation
        d = c + 44;
        wait_to(d);
        rd_empty = 1'b0; wr_empty = 1'b0; wr_lo_mark = 1'b0;
        expect_issue(d,      1'b0, "R3");
        expect_issue(d + 6,  1'b1, "R4");
        expect_issue(d + 10, 1'b1, "R5");
        expect_issue(d + 11 + T_PREP + 1, 1'b0, "R10");
        wait_to(d + 1);
        wr_hi_mark = 1'b1;
        wait_to(d + 7);
        wr_hi_mark = 1'b0;
        wait_to(d + 11);
        wr_lo_mark = 1'b1; rd_bank_ready = 1'b0;
        check_dir(d + 20, 2'd3, "R10");
        wait_to(d + 23);
        rd_empty = 1'b1; wr_empty = 1'b1; rd_bank_ready = 1'b1;
        wait_to(d + 30);
        drain_check("R10");

        // unprepared read in read state, serial preparation after read-to-write
        e = d + 34;
        wait_to(e);
        rd_empty = 1'b0; rd_bank_ready = 1'b0;
        expect_issue(e + T_PREP, 1'b0, "R12");
        expect_issue(e + 16 + T_PREP, 1'b1, "R11");
        wait_to(e + 11);
        rd_empty = 1'b1; rd_bank_ready = 1'b1;
        wr_empty = 1'b0; wr_lo_mark = 1'b0; wr_bank_ready = 1'b0;
        check_dir(e + 16, 2'd2, "R11");
        wait_to(e + 27);
        wr_empty = 1'b1; wr_lo_mark = 1'b1; wr_bank_ready = 1'b1;
        check_dir(e + 30, 2'd2, "R5");
        drain_check("R11");

        // reset from the write state
        wait_to(e + 32);
        rst = 1'b1;
        check_dir(e + 33, 2'd0, "R1");
        wait_to(e + 35);
        rst = 1'b0;
        check_dir(e + 38, 2'd0, "R1");
        drain_check("R6");

        finish_up();
    end
endmodule